// File: doc/BRIEF.md
# Generic N-Way Cache Tag and Data Array

This block is a single cache level that stores whole lines together with their tags. On the processor side it accepts one request at a time: a 32-bit byte address, a read or write flag, a 32-bit write word and four byte enables. On the memory side it issues line fills, whole-line writebacks and strobed word writes. Each request is accepted in one cycle and finishes with a one-cycle response pulse. That pulse carries the hit flag and, for reads, the addressed word.

Three parameters shape the array: the total capacity, the line size and the number of ways. The set count follows from them. A single way gives a direct-mapped cache. Setting the ways equal to the line count gives one set, so the index field disappears and the cache is fully associative. A fourth parameter selects the write policy. One choice is write-back with allocation on a write miss. The other is write-through with no allocation. Two counters report hits and the replacements of valid lines, so that a trace-driven model can be compared against them.

Top module: `sa_cache`

## Requirements
- R1: The number of sets is CACHE_BYTES / (LINE_BYTES * WAYS). The offset field is the low log2(LINE_BYTES) address bits and the index field is the next log2(sets) bits. The tag is the remaining upper bits. Lines with the same tag but different index do not conflict.
- R2: A request hits when some valid way of the indexed set holds its tag, and resp_hit is then 1. Otherwise resp_hit is 0. All lines are invalid after reset, and no tag is present in two valid ways of one set.
- R3: A read returns the current value of the addressed word. The word inside a line is chosen by address bits [log2(LINE_BYTES)-1:2]. On a write, req_be bit b replaces byte b (bits 8b+7..8b) of that word and leaves its other bytes unchanged.
- R4: A line is allocated into the lowest-numbered invalid way of the set. When no way is invalid, the least recently used way is replaced, where each hit and each fill counts as a use.
- R5: In write-back mode, a write marks its line dirty. Replacing a dirty line first issues one line writeback of the full line with all strobes set, and only then the fill. A clean line is never written back.
- R6: In write-back mode, a write miss fetches the line first and then merges the write into it, so that a later access to that line hits.
- R7: In write-through mode, every write sends one memory write of the addressed word. mem_wstrb has bit (4*word + b) set for each enabled byte b, and the word is copied into every word slot of mem_wline. A write miss performs no fill and leaves the cache unchanged, so a following read of that line misses.
- R8: req_ready is 1 only while idle. After a request is accepted it stays 0 until the response, and resp_valid is a single-cycle pulse, exactly one per request.
- R9: hit_count increments by one in the cycle of each hit response. repl_count increments by one for each fill that displaces a valid line.
- R10: A memory request holds mem_req_valid, address and direction steady until mem_ack. mem_req_addr is line aligned, and a fill takes mem_rline in the cycle where mem_ack is 1.
- R11: The same logic serves a direct-mapped configuration (WAYS = 1) and a fully associative configuration (one set, no index bits), and both follow R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables of the write word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | The request hit |
| resp_rdata | output | 32 | Read word (zero for writes) |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | 1 for writeback or write-through, 0 for fill |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | LINE_BYTES*8 | Write data, whole line |
| mem_wstrb | output | LINE_BYTES | Byte strobes of mem_wline |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rline | input | LINE_BYTES*8 | Fill data, valid with mem_ack |
| hit_count | output | CNT_W | Hit counter |
| repl_count | output | CNT_W | Replacement counter |

## Verification
The bench builds three copies of the block at 256 bytes with 32-byte lines. The first is a 2-way, four-set copy in write-back mode. The second is a direct-mapped copy in write-through mode, which brings every no-allocate path and back-to-back conflict evictions within reach. The third is an 8-way copy with a single set in write-back mode, which exercises the zero-width index and long LRU chains. Dirty evictions are forced through tag pools slightly larger than the way count, and memory latency is randomized.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL,
        ST_WTHRU
    } cache_state_e;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 25,
    parameter int WAY_W = 1
) (
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAYS-1:0]  hit_vec
);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == req_tag);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] way_age [WAYS],
    output logic [WAY_W-1:0] victim
);

    always_comb begin
        victim = '0;
        // oldest way first, then override with the lowest invalid way
        for (int w = 0; w < WAYS; w++) begin
            if (way_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_lru_update.sv
module cache_lru_update #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAY_W-1:0] way_age [WAYS],
    input  logic [WAY_W-1:0] touch,
    output logic [WAY_W-1:0] next_age [WAYS]
);

    logic [WAY_W-1:0] ref_age;

    always_comb begin
        ref_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (touch == WAY_W'(w)) ref_age = way_age[w];
        end
        for (int w = 0; w < WAYS; w++) begin
            if (touch == WAY_W'(w))        next_age[w] = '0;
            else if (way_age[w] < ref_age) next_age[w] = way_age[w] + 1'b1;
            else                           next_age[w] = way_age[w];
        end
    end

endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int CACHE_BYTES = 256,
    parameter int LINE_BYTES  = 32,
    parameter int WAYS        = 2,
    parameter int WRITE_BACK  = 1,
    parameter int CNT_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [31:0]             req_addr,
    input  logic [31:0]             req_wdata,
    input  logic [3:0]              req_be,
    output logic                    resp_valid,
    output logic                    resp_hit,
    output logic [31:0]             resp_rdata,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [31:0]             mem_req_addr,
    output logic [LINE_BYTES*8-1:0] mem_wline,
    output logic [LINE_BYTES-1:0]   mem_wstrb,
    input  logic                    mem_ack,
    input  logic [LINE_BYTES*8-1:0] mem_rline,
    output logic [CNT_W-1:0]        hit_count,
    output logic [CNT_W-1:0]        repl_count
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int SETS   = LINES / WAYS;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = 32 - OFF_W - IDX_W;
    localparam int SET_W  = (IDX_W > 0) ? IDX_W : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        cache_state_e     state;
        logic [31:0]      addr;
        logic             write;
        logic [31:0]      wdata;
        logic [3:0]       be;
        logic [WAY_W-1:0] victim;
        logic             vict_valid;
        logic             was_hit;
        logic             resp_valid;
        logic             resp_hit;
        logic [31:0]      resp_rdata;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] repls;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // line storage
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic              valid_q [SETS][WAYS];
    logic              dirty_q [SETS][WAYS];
    logic [WAY_W-1:0]  age_q   [SETS][WAYS];

    // request fields of the latched address
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  tag_req;
    logic [WSEL_W-1:0] wsel;

    assign set_q   = (SETS == 1) ? '0 : SET_W'(ctl_q.addr >> OFF_W);
    assign tag_req = TAG_W'(ctl_q.addr >> (OFF_W + IDX_W));
    assign wsel    = WSEL_W'(ctl_q.addr >> 2);

    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [WAY_W-1:0]  way_age  [WAYS];
    logic [WAY_W-1:0]  age_next [WAYS];
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim_pick, touch_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            way_tag[w]   = tag_q[set_q][w];
            way_valid[w] = valid_q[set_q][w];
            way_age[w]   = age_q[set_q][w];
        end
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_tag  (way_tag),
        .way_valid(way_valid),
        .req_tag  (tag_req),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_vec  (hit_vec)
    );

    cache_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .way_valid(way_valid),
        .way_age  (way_age),
        .victim   (victim_pick)
    );

    assign touch_way = (ctl_q.state == ST_FILL) ? ctl_q.victim : hit_way;

    cache_lru_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
        .way_age (way_age),
        .touch   (touch_way),
        .next_age(age_next)
    );

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] ws,
        input logic [31:0]       wd,
        input logic [3:0]        be
    );
        logic [LINE_W-1:0] r;
        r = line;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (be[b]) r[int'(ws)*WORD_BITS + b*8 +: 8] = wd[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] pick_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] ws
    );
        return line[int'(ws)*WORD_BITS +: WORD_BITS];
    endfunction

    // storage write controls
    logic              ln_we, ln_dirty, age_we;
    logic [WAY_W-1:0]  ln_way;
    logic [LINE_W-1:0] ln_data;

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.resp_valid = 1'b0;
        ln_we            = 1'b0;
        ln_dirty         = 1'b0;
        ln_way           = hit_way;
        ln_data          = data_q[set_q][hit_way];
        age_we           = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.write = req_write;
                    ctl_d.wdata = req_wdata;
                    ctl_d.be    = req_be;
                    ctl_d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                ctl_d.was_hit = hit;
                if (hit) begin
                    age_we = 1'b1;
                    if (ctl_q.write) begin
                        ln_we    = 1'b1;
                        ln_data  = merge_word(data_q[set_q][hit_way], wsel,
                                              ctl_q.wdata, ctl_q.be);
                        ln_dirty = (WRITE_BACK != 0) ? 1'b1 : dirty_q[set_q][hit_way];
                    end
                    if (ctl_q.write && WRITE_BACK == 0) begin
                        ctl_d.state = ST_WTHRU;
                    end else begin
                        ctl_d.resp_valid = 1'b1;
                        ctl_d.resp_hit   = 1'b1;
                        ctl_d.resp_rdata = ctl_q.write ? 32'd0
                                         : pick_word(data_q[set_q][hit_way], wsel);
                        ctl_d.hits       = ctl_q.hits + 1'b1;
                        ctl_d.state      = ST_IDLE;
                    end
                end else if (ctl_q.write && WRITE_BACK == 0) begin
                    ctl_d.state = ST_WTHRU;
                end else begin
                    ctl_d.victim     = victim_pick;
                    ctl_d.vict_valid = valid_q[set_q][victim_pick];
                    if (WRITE_BACK != 0 && valid_q[set_q][victim_pick]
                        && dirty_q[set_q][victim_pick])
                        ctl_d.state = ST_WBACK;
                    else
                        ctl_d.state = ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ack) ctl_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    ln_we            = 1'b1;
                    age_we           = 1'b1;
                    ln_way           = ctl_q.victim;
                    ln_dirty         = ctl_q.write;
                    ln_data          = ctl_q.write
                                     ? merge_word(mem_rline, wsel, ctl_q.wdata, ctl_q.be)
                                     : mem_rline;
                    ctl_d.repls      = ctl_q.repls + CNT_W'(ctl_q.vict_valid);
                    ctl_d.resp_valid = 1'b1;
                    ctl_d.resp_hit   = 1'b0;
                    ctl_d.resp_rdata = ctl_q.write ? 32'd0 : pick_word(mem_rline, wsel);
                    ctl_d.state      = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                if (mem_ack) begin
                    ctl_d.resp_valid = 1'b1;
                    ctl_d.resp_hit   = ctl_q.was_hit;
                    ctl_d.resp_rdata = 32'd0;
                    ctl_d.hits       = ctl_q.hits + CNT_W'(ctl_q.was_hit);
                    ctl_d.state      = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                    age_q[s][w]   <= WAY_W'(w);
                end
            end
        end else begin
            if (ln_we) begin
                valid_q[set_q][ln_way] <= 1'b1;
                dirty_q[set_q][ln_way] <= ln_dirty;
            end
            if (age_we) begin
                for (int w = 0; w < WAYS; w++) age_q[set_q][w] <= age_next[w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ln_we) begin
            tag_q[set_q][ln_way]  <= tag_req;
            data_q[set_q][ln_way] <= ln_data;
        end
    end

    // memory side
    logic [31:0] line_addr, vict_addr;
    assign line_addr = (ctl_q.addr >> OFF_W) << OFF_W;
    assign vict_addr = (32'(tag_q[set_q][ctl_q.victim]) << (OFF_W + IDX_W))
                     | (32'(set_q) << OFF_W);

    always_comb begin
        mem_req_valid = ctl_q.state inside {ST_WBACK, ST_FILL, ST_WTHRU};
        mem_req_write = (ctl_q.state == ST_WBACK) || (ctl_q.state == ST_WTHRU);
        mem_req_addr  = (ctl_q.state == ST_WBACK) ? vict_addr : line_addr;
        mem_wline     = (ctl_q.state == ST_WBACK) ? data_q[set_q][ctl_q.victim]
                                                  : {WORDS{ctl_q.wdata}};
        if (ctl_q.state == ST_WBACK)
            mem_wstrb = '1;
        else if (ctl_q.state == ST_WTHRU)
            mem_wstrb = LINE_BYTES'(ctl_q.be) << (int'(wsel) * WORD_BYTES);
        else
            mem_wstrb = '0;
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign resp_valid = ctl_q.resp_valid;
    assign resp_hit   = ctl_q.resp_hit;
    assign resp_rdata = ctl_q.resp_rdata;
    assign hit_count  = ctl_q.hits;
    assign repl_count = ctl_q.repls;

    // checks
    assert_unique_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_LOOKUP) |-> $onehot0(hit_vec));

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_hit_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (hit_count == $past(hit_count) + CNT_W'(resp_hit)));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_ack && WRITE_BACK != 0)
            |=> (mem_req_valid && !mem_req_write));

    assert_wt_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK == 0 && mem_req_valid && !mem_req_write) |-> !ctl_q.write);

endmodule

// File: tb/sa_cache_env.sv
module sa_cache_env #(
    parameter int WAYS       = 2,
    parameter int WRITE_BACK = 1,
    parameter int NOPS       = 300
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_run,
    output int   n_fail
);

    localparam int CACHE_BYTES = 256;
    localparam int LINE_BYTES  = 32;
    localparam int LINE_W      = LINE_BYTES * 8;
    localparam int SETS        = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int IDX_W       = $clog2(SETS);
    localparam int WORDS       = LINE_BYTES / 4;

    logic              req_valid, req_ready, req_write;
    logic [31:0]       req_addr, req_wdata, resp_rdata, mem_req_addr;
    logic [3:0]        req_be;
    logic              resp_valid, resp_hit, mem_req_valid, mem_req_write, mem_ack;
    logic [LINE_W-1:0] mem_wline, mem_rline;
    logic [LINE_BYTES-1:0] mem_wstrb;
    logic [15:0]       hit_count, repl_count;

    sa_cache #(.CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES), .WAYS(WAYS),
               .WRITE_BACK(WRITE_BACK), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_wline(mem_wline), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rline(mem_rline),
        .hit_count(hit_count), .repl_count(repl_count)
    );

    // reference state
    int unsigned m_tag  [SETS][WAYS];
    bit          m_val  [SETS][WAYS];
    bit          m_dirty[SETS][WAYS];
    int          m_age  [SETS][WAYS];
    int          m_hits, m_repls;
    logic [LINE_W-1:0] gold [int unsigned];
    logic [LINE_W-1:0] back [int unsigned];

    int          got_wb, got_fill, got_wt, wait_n;
    int unsigned wb_la;

    function automatic logic [LINE_W-1:0] seed_line(input int unsigned la);
        logic [LINE_W-1:0] r;
        for (int w = 0; w < WORDS; w++)
            r[w*32 +: 32] = (la * 32'h9E3779B1) ^ (32'(w) * 32'h01010101) ^ 32'h5A5A0000;
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] gold_line(input int unsigned la);
        return gold.exists(la) ? gold[la] : seed_line(la);
    endfunction

    function automatic logic [LINE_W-1:0] back_line(input int unsigned la);
        return back.exists(la) ? back[la] : seed_line(la);
    endfunction

    function automatic logic [31:0] make_addr(input int unsigned tg, input int s, input int ws);
        return (tg << (OFF_W + IDX_W)) | (32'(s) << OFF_W) | (32'(ws) << 2);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (ways=%0d wb=%0d) actual=%0h expected=%0h",
                     req, WAYS, WRITE_BACK, act, exp);
        end
    endtask

    task automatic touch(input int s, input int w);
        int r = m_age[s][w];
        for (int x = 0; x < WAYS; x++) begin
            if (x == w) m_age[s][x] = 0;
            else if (m_age[s][x] < r) m_age[s][x]++;
        end
    endtask

    // memory responder
    initial begin
        mem_ack = 1'b0; mem_rline = '0; wait_n = -1;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0; wait_n = -1;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req_valid) begin
                if (wait_n < 0) wait_n = int'($urandom % 3);
                if (wait_n == 0) begin
                    automatic int unsigned la = mem_req_addr >> OFF_W;
                    chk(mem_req_addr[OFF_W-1:0] == 0, "R10 line alignment",
                        64'(mem_req_addr), 64'(la << OFF_W));
                    if (mem_req_write && WRITE_BACK != 0) begin
                        got_wb++; wb_la = la;
                        chk(mem_wstrb == '1, "R5 writeback strobes", 64'(mem_wstrb), '1);
                        chk(mem_wline == gold_line(la), "R5 writeback data",
                            mem_wline[63:0], gold_line(la) >> 0);
                        back[la] = mem_wline;
                    end else if (mem_req_write) begin
                        automatic logic [LINE_W-1:0] b = back_line(la);
                        got_wt++;
                        for (int i = 0; i < LINE_BYTES; i++)
                            if (mem_wstrb[i]) b[i*8 +: 8] = mem_wline[i*8 +: 8];
                        back[la] = b;
                    end else begin
                        got_fill++;
                        mem_rline = back_line(la);
                    end
                    mem_ack = 1'b1;
                    wait_n  = -1;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output bit hit_o);
        int unsigned la = addr >> OFF_W;
        int          s  = int'((addr >> OFF_W) % SETS);
        int unsigned tg = addr >> (OFF_W + IDX_W);
        int          ws = int'((addr >> 2) % WORDS);
        bit          hit = 0, exp_wb = 0, exp_fill = 0, exp_wt, rdy_bad = 0;
        int          hw = 0, v = 0, guard = 0;
        int unsigned exp_wb_la = 0;
        logic [LINE_W-1:0] g;
        logic [31:0] exp_rd;

        for (int w = 0; w < WAYS; w++)
            if (m_val[s][w] && m_tag[s][w] == tg) begin hit = 1; hw = w; end
        exp_wt = wr && (WRITE_BACK == 0);
        if (hit) begin
            touch(s, hw);
            if (wr && WRITE_BACK != 0) m_dirty[s][hw] = 1;
            m_hits++;
        end else if (!wr || WRITE_BACK != 0) begin
            for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) v = w;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) v = w;
            exp_fill = 1;
            if (m_val[s][v]) begin
                m_repls++;
                if (m_dirty[s][v]) begin
                    exp_wb = 1;
                    exp_wb_la = m_tag[s][v] * SETS + s;
                end
            end
            m_tag[s][v] = tg; m_val[s][v] = 1; m_dirty[s][v] = wr;
            touch(s, v);
        end
        g = gold_line(la);
        exp_rd = g[ws*32 +: 32];
        if (wr) begin
            for (int b = 0; b < 4; b++) if (be[b]) g[ws*32 + b*8 +: 8] = wd[b*8 +: 8];
            gold[la] = g;
        end

        got_wb = 0; got_fill = 0; got_wt = 0;
        @(negedge clk);
        chk(req_ready, "R8 ready while idle", 64'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && guard < 2000) begin
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
            guard++;
        end
        chk(resp_valid, "R8 response arrives", 64'(resp_valid), 1);
        chk(!rdy_bad, "R8 ready low while busy", 64'(rdy_bad), 0);
        chk(resp_hit == hit, "R2 hit flag", 64'(resp_hit), 64'(hit));
        if (!wr) chk(resp_rdata == exp_rd, "R3 read data", 64'(resp_rdata), 64'(exp_rd));
        chk(got_wb == int'(exp_wb), "R5 writeback count", 64'(got_wb), 64'(exp_wb));
        if (exp_wb) chk(wb_la == exp_wb_la, "R5 writeback address", 64'(wb_la), 64'(exp_wb_la));
        chk(got_fill == int'(exp_fill), "R6 fill count", 64'(got_fill), 64'(exp_fill));
        chk(got_wt == int'(exp_wt), "R7 write-through count", 64'(got_wt), 64'(exp_wt));
        if (WRITE_BACK == 0 && wr)
            chk(back_line(la) == gold_line(la), "R7 memory updated",
                back_line(la) >> 0, gold_line(la) >> 0);
        hit_o = hit;
        @(negedge clk);
        chk(!resp_valid, "R8 single response pulse", 64'(resp_valid), 0);
    endtask

    initial begin
        bit h;
        int wb_before;
        done = 1'b0; n_run = 0; n_fail = 0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
        m_hits = 0; m_repls = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_dirty[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = 0;
            end
        @(posedge rst_n);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 reset ready", 64'(req_ready), 1);
        chk(resp_valid == 1'b0, "R8 reset response", 64'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R10 reset memory idle", 64'(mem_req_valid), 0);
        chk(hit_count == 0 && repl_count == 0, "R9 reset counters",
            64'({hit_count, repl_count}), 0);

        // R1 / R11: same tag in two sets, then revisit the first
        access(0, make_addr(7, 0, 0), 0, 0, h);
        chk(!h, "R2 first access after reset misses", 64'(h), 0);
        access(0, make_addr(7, SETS - 1, 1), 0, 0, h);
        access(0, make_addr(7, 0, 2), 0, 0, h);
        chk(h, "R1 R11 separate sets keep both lines", 64'(h), 1);

        // R4: fill WAYS+1 tags into one set; the first one is evicted
        for (int i = 0; i <= WAYS; i++) access(0, make_addr(100 + i, 1 % SETS, 0), 0, 0, h);
        access(0, make_addr(100, 1 % SETS, 3), 0, 0, h);
        chk(!h, "R4 LRU line was replaced", 64'(h), 0);
        access(0, make_addr(100, 1 % SETS, 4), 0, 0, h);
        chk(h, "R4 refetched line hits", 64'(h), 1);

        // R3 / R6 / R7: partial write then read back
        access(1, make_addr(150, 2 % SETS, 5), 32'hAABBCCDD, 4'b0101, h);
        access(0, make_addr(150, 2 % SETS, 5), 0, 0, h);
        if (WRITE_BACK != 0) chk(h, "R6 write miss allocates", 64'(h), 1);
        else                 chk(!h, "R7 write miss does not allocate", 64'(h), 0);

        // R5: dirty a line then push it out of its set
        wb_before = 0;
        access(1, make_addr(200, 0, 0), 32'h12345678, 4'hF, h);
        for (int i = 1; i <= WAYS; i++) begin
            access(0, make_addr(200 + i, 0, 0), 0, 0, h);
            wb_before += got_wb;
        end
        if (WRITE_BACK != 0) chk(wb_before >= 1, "R5 dirty eviction writes back", 64'(wb_before), 1);
        else                 chk(wb_before == 0, "R5 no writeback in write-through", 64'(wb_before), 0);

        // constrained random traffic
        for (int n = 0; n < NOPS; n++) begin
            automatic int unsigned tg = 300 + ($urandom % (WAYS + 3));
            automatic int s  = int'($urandom % SETS);
            automatic int ws = int'($urandom % WORDS);
            automatic bit wr = ($urandom % 10) < 4;
            access(wr, make_addr(tg, s, ws), $urandom, 4'(($urandom % 15) + 1), h);
        end

        @(negedge clk);
        chk(hit_count == 16'(m_hits), "R9 hit counter", 64'(hit_count), 64'(m_hits));
        chk(repl_count == 16'(m_repls), "R9 replacement counter", 64'(repl_count), 64'(m_repls));
        done = 1'b1;
    end

endmodule

// File: tb/sa_cache_tb.sv
module sa_cache_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d0, d1, d2;
    int   r0, r1, r2, f0, f1, f2;

    always #10 clk = ~clk;

    // 2-way write-back, direct-mapped write-through, fully associative write-back
    sa_cache_env #(.WAYS(2), .WRITE_BACK(1), .NOPS(300)) u_env_2w (
        .clk(clk), .rst_n(rst_n), .done(d0), .n_run(r0), .n_fail(f0));
    sa_cache_env #(.WAYS(1), .WRITE_BACK(0), .NOPS(300)) u_env_dm (
        .clk(clk), .rst_n(rst_n), .done(d1), .n_run(r1), .n_fail(f1));
    sa_cache_env #(.WAYS(8), .WRITE_BACK(1), .NOPS(300)) u_env_fa (
        .clk(clk), .rst_n(rst_n), .done(d2), .n_run(r2), .n_fail(f2));

    initial begin
        int cycles = 0;
        int wd_fail = 0;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (cycles >= 150000) begin
            wd_fail = 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cycles, 150000);
        end
        $display("  [TB] %0d tests run, %0d failed", r0 + r1 + r2 + wd_fail,
                 f0 + f1 + f2 + wd_fail);
        $finish;
    end

endmodule